// File: doc/BRIEF.md
# SD-card command path controller

This block sends one command frame on the serial command line of an SD card and, when asked, collects the card's reply. The host presents a 6-bit command index, a 32-bit argument and a 2-bit reply-type code, then pulses `start`. The block forms a 48-bit frame and shifts it out, most significant bit first, one bit per card-clock event. The event is signalled by `tick`, a one-cycle enable on the system clock. Card clock generation and the data lines are handled elsewhere.

After the end bit the block either finishes at once or listens on `cmd_in` for a 48-bit short reply or a 136-bit long reply. A reply begins at the first low bit on the line. The block captures the echoed index and up to four 32-bit reply words and checks the reply CRC7. Every outcome sets exactly one sticky flag, and the host clears a flag by pulsing its bit in `clr`.

Top module: `sd_cmd_path`

## Requirements
- R1: After reset `cmd_out` is 1, `busy` is 0, `flags` is 0 and `rsp_data` is 0.
- R2: A `start` pulse is accepted only while `busy` is 0, and `busy` is 1 from the next clock until the command finishes. A `start` pulse, or a change of index or argument, while `busy` is 1 does not alter the frame being sent.
- R3: The frame is 48 bits sent MSB first, one bit per `tick`: a 0, then a 1, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero start value) over those first 40 bits, and a final 1. Outside a frame `cmd_out` is 1. For index 0 and argument 0 the frame is 48'h400000000095.
- R4: Reply-type codes 2'b00 and 2'b10 both mean no reply. The tick that sends the end bit sets `flags[0]` (sent), and `busy` drops at the same clock edge.
- R5: Code 2'b01 selects a 48-bit short reply. The reply's bits 2..7 go to `rsp_idx`, and its bits 8..39 go to `rsp_data[127:96]`, with the lower 96 bits cleared. If bits 40..46 equal the CRC7 of bits 0..39, `flags[1]` (reply OK) is set. Otherwise `flags[2]` (CRC fail) is set.
- R6: Code 2'b11 selects a 136-bit long reply. Bits 2..7 go to `rsp_idx`, and bits 8..135 fill `rsp_data` from bit 127 downward, so word 0 sits in [127:96] and the end bit lands in bit 0. If bits 128..134 equal the CRC7 of bits 8..127, `flags[1]` is set. Otherwise `flags[2]` is set.
- R7: The reply start bit is accepted on any of the first 64 ticks after the end-bit tick. If the line stays 1 for all 64 ticks, `flags[3]` (timeout) is set and `busy` drops.
- R8: A flag stays set until a clock in which its `clr` bit is 1. A set and a clear on the same clock leave the flag set. No two flags rise on the same clock.
- R9: `cmd_out` changes only at clocks where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle card-clock event enable |
| start | input | 1 | Launch pulse for a command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | Reply type: 00/10 none, 01 short, 11 long |
| clr | input | 4 | Write-one flag clear, one bit per flag |
| cmd_in | input | 1 | Sampled command line from the card |
| cmd_out | output | 1 | Driven command line |
| busy | output | 1 | Command in progress |
| flags | output | 4 | Sticky flags: 0 sent, 1 reply OK, 2 CRC fail, 3 timeout |
| rsp_idx | output | 6 | Echoed index from the last reply |
| rsp_data | output | 128 | Reply words, word 0 in [127:96] |

## Verification
The bench sweeps all 64 command indices, alternating between the two no-reply codes. If the design decoded only one of those codes, it would hang waiting for a reply and would never set the sent flag. The bench also anchors the CRC with a known frame, because a wrong polynomial or shift order would corrupt the last byte of every frame. Replies are started on the first wait tick, on a middle tick and on the 64th tick, and a fourth case sends no reply at all. An off-by-one wait counter would report a false timeout on the 64th-tick case or miss the real one. Corrupted short and long replies must set the CRC-fail flag, and any misalignment of the long-reply CRC window would fail the good long reply instead. A clear landing on the same clock as a new set must leave the flag set.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int FRAME_W   = 48;
    localparam int LONG_W    = 136;
    localparam int HDR_W     = 8;
    localparam int IDX_W     = 6;
    localparam int WORD_W    = 32;
    localparam int RSP_WORDS = 4;
    localparam int RSP_W     = RSP_WORDS * WORD_W;
    localparam int CNT_W     = $clog2(LONG_W);
    localparam int CRC_W     = 7;
    localparam int NFLAGS    = 4;
    localparam int F_SENT    = 0;
    localparam int F_ROK     = 1;
    localparam int F_CRC     = 2;
    localparam int F_TMO     = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} st_e;

    // one serial step of x^7 + x^3 + 1
    function automatic logic [CRC_W-1:0] crc7_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    // parallel CRC over the 40 header bits of an outgoing frame
    function automatic logic [CRC_W-1:0] crc7_hdr(logic [FRAME_W-CRC_W-2:0] v);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = FRAME_W - CRC_W - 2; i >= 0; i--) c = crc7_step(c, v[i]);
        return c;
    endfunction
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = '0;
        else if (en) crc_d = crc7_step(crc_q, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdc_flags.sv
module sdc_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flg
);
    logic [N-1:0] flg_d, flg_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // a set in the same clock as a clear wins
        always_comb flg_d[g] = set[g] | (flg_q[g] & ~clr[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flg = flg_q;
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
    import sdc_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [WORD_W-1:0] cmd_arg,
    input  logic [1:0]        rsp_type,
    input  logic [NFLAGS-1:0] clr,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              busy,
    output logic [NFLAGS-1:0] flags,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [RSP_W-1:0]  rsp_data
);
    localparam int TMR_W    = $clog2(TMO_TICKS) + 1;
    localparam int SH_LO    = FRAME_W - 1 - HDR_W - WORD_W;
    localparam int TX_LAST  = FRAME_W - 1;
    localparam int LG_CRC_E = LONG_W - 2;
    localparam int SH_CRC_E = FRAME_W - 2;

    typedef struct packed {
        st_e                st;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   cnt;
        logic [TMR_W-1:0]   tmr;
        logic               long_r;
        logic               want_r;
        logic               out;
        logic [IDX_W-1:0]   ridx;
        logic [RSP_W-1:0]   sr;
        logic [RSP_W-1:0]   rsp;
    } regs_t;

    regs_t             r_d, r_q;
    logic [NFLAGS-1:0] set_v;
    logic              crc_clr, crc_en;
    logic [CRC_W-1:0]  crc_v;
    logic [CNT_W-1:0]  last_pos;

    sdc_crc7 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(cmd_in), .crc(crc_v)
    );

    sdc_flags #(.N(NFLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr), .flg(flags)
    );

    always_comb begin
        r_d      = r_q;
        set_v    = '0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        last_pos = r_q.long_r ? CNT_W'(LONG_W - 1) : CNT_W'(FRAME_W - 1);
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.out = 1'b1;
                if (start) begin
                    r_d.frame  = {2'b01, cmd_idx, cmd_arg,
                                  crc7_hdr({2'b01, cmd_idx, cmd_arg}), 1'b1};
                    r_d.cnt    = '0;
                    r_d.long_r = (rsp_type == 2'b11);
                    r_d.want_r = rsp_type[0];
                    r_d.st     = ST_TX;
                    crc_clr    = 1'b1;
                end
            end
            ST_TX: if (tick) begin
                r_d.out   = r_q.frame[FRAME_W-1];
                r_d.frame = {r_q.frame[FRAME_W-2:0], 1'b0};
                r_d.cnt   = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(TX_LAST)) begin
                    r_d.tmr = '0;
                    if (r_q.want_r) begin
                        r_d.st = ST_WAIT;
                    end else begin
                        r_d.st        = ST_IDLE;
                        set_v[F_SENT] = 1'b1;
                    end
                end
            end
            ST_WAIT: if (tick) begin
                if (!cmd_in) begin
                    r_d.st = ST_RX;
                    r_d.cnt = CNT_W'(1);
                    crc_en  = !r_q.long_r;
                end else if (r_q.tmr == TMR_W'(TMO_TICKS - 1)) begin
                    r_d.st       = ST_IDLE;
                    set_v[F_TMO] = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_RX: if (tick) begin
                if (r_q.long_r)
                    crc_en = (r_q.cnt >= CNT_W'(HDR_W)) && (r_q.cnt <= CNT_W'(LG_CRC_E));
                else
                    crc_en = (r_q.cnt <= CNT_W'(SH_CRC_E));
                if (r_q.cnt >= CNT_W'(2) && r_q.cnt < CNT_W'(HDR_W))
                    r_d.ridx = {r_q.ridx[IDX_W-2:0], cmd_in};
                if (r_q.cnt >= CNT_W'(HDR_W))
                    r_d.sr = {r_q.sr[RSP_W-2:0], cmd_in};
                if (r_q.cnt == last_pos) begin
                    r_d.st = ST_IDLE;
                    // a CRC-checked stream followed by its own CRC leaves zero
                    if (crc_v == '0) set_v[F_ROK] = 1'b1;
                    else             set_v[F_CRC] = 1'b1;
                    r_d.rsp = r_q.long_r ? {r_q.sr[RSP_W-2:0], cmd_in}
                                         : {r_q.sr[SH_LO+WORD_W-1:SH_LO], {(RSP_W-WORD_W){1'b0}}};
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.out <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_out  = r_q.out;
    assign busy     = (r_q.st != ST_IDLE);
    assign rsp_idx  = r_q.ridx;
    assign rsp_data = r_q.rsp;
endmodule

// File: rtl/sdc_cmd_chk.sv
module sdc_cmd_chk
    import sdc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              start,
    input logic [NFLAGS-1:0] clr,
    input logic              cmd_out,
    input logic              busy,
    input logic [NFLAGS-1:0] flags
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cmd_out);

    a_r9_out_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cmd_out));

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags & ~$past(flags)) <= 1);

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        a_r8_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[g]) |-> $past(clr[g]));
        a_r4_rise_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[g]) |-> !busy);
    end
endmodule

bind sd_cmd_path sdc_cmd_chk u_chk (.*);

// File: tb/sd_cmd_path_tb.sv
module sd_cmd_path_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   cmd_idx = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   rsp_type = '0;
    logic [3:0]   clr = '0;
    logic         cmd_in = 1'b1;
    logic         cmd_out, busy;
    logic [3:0]   flags;
    logic [5:0]   rsp_idx;
    logic [127:0] rsp_data;
    int           n_run = 0, n_fail = 0, r9_bad = 0;

    always #5 clk = ~clk;

    sd_cmd_path u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .rsp_type(rsp_type), .clr(clr), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .busy(busy), .flags(flags), .rsp_idx(rsp_idx),
        .rsp_data(rsp_data)
    );

    function automatic logic [6:0] bcrc(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic x;
            x = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (x) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] i, input logic [31:0] a);
        return {2'b01, i, a, bcrc({96'b0, 2'b01, i, a}, 40), 1'b1};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tk(input logic cin, input logic [3:0] cl, output logic o);
        @(negedge clk); cmd_in = cin; tick = 1'b1; clr = cl;
        @(negedge clk); tick = 1'b0; clr = '0; o = cmd_out;
        @(negedge clk); if (cmd_out !== o) r9_bad++;
    endtask

    task automatic clear_all();
        @(negedge clk); clr = 4'hF;
        @(negedge clk); clr = '0;
    endtask

    task automatic send(input logic [5:0] i, input logic [31:0] a, input logic [1:0] t,
                        input bit poke, input logic [3:0] cl_last, output logic [47:0] seen);
        logic o;
        @(negedge clk); cmd_idx = i; cmd_arg = a; rsp_type = t; start = 1'b1;
        @(negedge clk); start = 1'b0;
        seen = '0;
        for (int k = 0; k < 48; k++) begin
            if (poke && k == 10) begin
                @(negedge clk); cmd_idx = ~i; cmd_arg = ~a; start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
            tk(1'b1, (k == 47) ? cl_last : 4'h0, o);
            seen = {seen[46:0], o};
        end
    endtask

    task automatic respond(input logic [135:0] bits, input int len, input int dly);
        logic o;
        for (int k = 0; k < dly; k++) tk(1'b1, 4'h0, o);
        for (int k = len - 1; k >= 0; k--) tk(bits[k], 4'h0, o);
        @(negedge clk); cmd_in = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [47:0]  seen;
        logic [135:0] bits;
        logic [119:0] pay;
        logic [39:0]  hd;
        logic         o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_out", cmd_out, 1);
        chk("R1 busy", busy, 0);
        chk("R1 flags", flags, 0);
        chk("R1 rsp_data", rsp_data, 0);

        // R3 known frame anchor
        send(6'd0, 32'd0, 2'b00, 0, 4'h0, seen);
        chk("R3 anchor frame", seen, 48'h400000000095);
        clear_all();

        // R3/R4 sweep over every index, both no-reply codes
        for (int k = 0; k < 64; k++) begin
            logic [31:0] a;
            a = 32'h9E3779B9 * (k + 1);
            send(6'(k), a, (k % 2 == 1) ? 2'b10 : 2'b00, 0, 4'h0, seen);
            chk("R3 frame", seen, exp_frame(6'(k), a));
            chk("R4 sent flag", {busy, flags}, 5'b00001);
            clear_all();
            chk("R8 cleared", flags, 0);
        end

        // R2 start and field changes ignored while busy
        send(6'd5, 32'hCAFE0123, 2'b00, 1, 4'h0, seen);
        chk("R2 frame kept", seen, exp_frame(6'd5, 32'hCAFE0123));
        chk("R2 idle after", busy, 0);
        clear_all();

        // R8 set and clear in the same clock: set wins
        send(6'd9, 32'h1, 2'b00, 0, 4'h0, seen);
        send(6'd9, 32'h2, 2'b00, 0, 4'h1, seen);
        chk("R8 set beats clear", flags, 4'b0001);
        @(negedge clk); clr = 4'h2;
        @(negedge clk); clr = '0;
        chk("R8 other clear no effect", flags, 4'b0001);
        clear_all();

        // R5 short replies, R7 start on first, middle and last accepted tick
        for (int k = 0; k < 3; k++) begin
            logic [31:0] st;
            logic [5:0]  ri;
            int          dl;
            st = 32'h0000_0900 ^ (32'h13579BDF << k);
            ri = 6'(17 + k);
            dl = (k == 0) ? 0 : ((k == 1) ? 5 : 63);
            send(ri, 32'h55AA00FF, 2'b01, 0, 4'h0, seen);
            chk("R5 busy in wait", busy, 1);
            hd = {2'b00, ri, st};
            bits = {88'b0, hd, bcrc({96'b0, hd}, 40), 1'b1};
            respond(bits, 48, dl);
            chk("R5 R7 short ok flags", {busy, flags}, 5'b00010);
            chk("R5 rsp_idx", rsp_idx, ri);
            chk("R5 rsp_data", rsp_data, {st, 96'b0});
            clear_all();
        end

        // R5 short reply with corrupt CRC
        hd = {2'b00, 6'd8, 32'h000001AA};
        bits = {88'b0, hd, bcrc({96'b0, hd}, 40) ^ 7'h04, 1'b1};
        send(6'd8, 32'h1AA, 2'b01, 0, 4'h0, seen);
        respond(bits, 48, 2);
        chk("R5 short crc fail", {busy, flags}, 5'b00100);
        clear_all();

        // R6 long reply, good then corrupt
        pay = {32'h03534453, 32'h55303847, 32'h80FF1234, 24'h5601A7};
        bits = {2'b00, 6'h3F, pay, bcrc({16'b0, pay}, 120), 1'b1};
        send(6'd2, 32'h0, 2'b11, 0, 4'h0, seen);
        respond(bits, 136, 3);
        chk("R6 long ok flags", {busy, flags}, 5'b00010);
        chk("R6 long words", rsp_data, {pay, bcrc({16'b0, pay}, 120), 1'b1});
        chk("R6 long idx", rsp_idx, 6'h3F);
        clear_all();
        bits[70] = ~bits[70];
        send(6'd2, 32'h0, 2'b11, 0, 4'h0, seen);
        respond(bits, 136, 1);
        chk("R6 long crc fail", {busy, flags}, 5'b00100);
        clear_all();

        // R7 timeout after 64 high ticks
        send(6'd41, 32'h0, 2'b11, 0, 4'h0, seen);
        for (int k = 0; k < 63; k++) tk(1'b1, 4'h0, o);
        chk("R7 still waiting at 63", {busy, flags}, 5'b10000);
        tk(1'b1, 4'h0, o);
        chk("R7 timeout", {busy, flags}, 5'b01000);
        clear_all();

        chk("R9 out stable between ticks", r9_bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule